// File: doc/BRIEF.md
# External Bus Strobe Generator

This block times the two strobes of an 8-bit controller's multiplexed external memory bus. A machine cycle lasts twelve oscillator periods. A six-state sequencer splits it into states ST_S1 through ST_S6, and each state lasts two oscillator periods. The address-latch strobe `ale` is a high pulse: the external latch captures the low address byte on its falling edge. The program-store strobe `psen_n` is an active-low read pulse for external code memory.

Four inputs describe each machine cycle: external data access, table read, external execution and the software latch-disable bit. The block samples them on the edge that enters ST_S1 and holds them for the whole cycle. These sampled values decide which pulses are dropped and whether the latch strobe is held high. The sequencer steps ST_S1 → ST_S2 → … → ST_S6 → ST_S1. It takes one step on every second oscillator edge, and a half bit marks the first or second period of each state.

A second part qualifies the raw reset pin. The pin passes through a two-flop synchronizer into a three-state machine. The states are RQ_IDLE, RQ_COUNT and RQ_HOLD. RQ_IDLE moves to RQ_COUNT when the synchronized pin is high. RQ_COUNT moves to RQ_HOLD after two full machine cycles of high samples. Both RQ_COUNT and RQ_HOLD return to RQ_IDLE as soon as a low sample arrives. The internal reset is high in RQ_HOLD only.

Top module: `xbus_strobe_gen`

## Requirements
- R1: While `por_n` is low, `ale` is 1, `psen_n` is 1 and `int_rst` is 0, and the sequencer rests in ST_S1, first period. The first edge after release enters the second period of ST_S1.
- R2: Phase p (0 to 11) is the count of oscillator edges since `por_n` rose, modulo 12, and phase p lies in state ST_S(p/2+1). In a plain cycle `ale` is 1 in phases 0, 1, 6 and 7 and 0 in the other phases. This gives two pulses per machine cycle at one sixth of the oscillator rate.
- R3: Every `ale` high pulse and every `psen_n` low pulse lasts exactly two oscillator periods. Both outputs come straight from flip-flops.
- R4: When the cycle's sampled external-execution flag is 1 and no data access is sampled, `psen_n` is 0 in phases 4, 5, 10 and 11 (ST_S3 and ST_S6). Otherwise `psen_n` stays 1.
- R5: `xdata_acc`, `tblrd_acc`, `ext_exec` and `ale_off` are sampled only on the edge that enters phase 0. Changes during the rest of the cycle have no effect until the next cycle.
- R6: In a cycle sampled with `xdata_acc`=1, the `ale` pulse in phases 6 and 7 is dropped and both `psen_n` pulses are dropped.
- R7: When `ale_off`=1 and `ext_exec`=0, `ale` is held at 1 for the whole cycle, unless `xdata_acc` or `tblrd_acc` was sampled as 1. In those cycles the normal pattern, including R6, applies.
- R8: `ext_exec`=1 overrides `ale_off`, so `ale` follows R2 and R6.
- R9: `int_rst` rises on the 26th rising edge after `rst_pin` goes high: two edges through the synchronizer and 24 edges (two machine cycles) of qualification. It is still 0 after the 25th edge.
- R10: `int_rst` falls on the 3rd edge after `rst_pin` goes low. A high pulse on `rst_pin` shorter than the qualification window never raises `int_rst`.
- R11: In a table-read cycle without data access, both `ale` pulses are present, even with `ale_off`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_pin | input | 1 | Raw external reset pin, asynchronous to nothing but unqualified |
| xdata_acc | input | 1 | Current machine cycle is an external data-memory access |
| tblrd_acc | input | 1 | Current machine cycle belongs to a code-table read |
| ext_exec | input | 1 | Controller fetches code from external memory |
| ale_off | input | 1 | Software latch-disable bit |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| int_rst | output | 1 | Qualified internal reset |

## Verification
A sequencer state that slips or skips shifts the `ale` and `psen_n` windows against the edge count. The per-phase scoreboard catches this within one state, which is two oscillator periods. A wrong sampled cycle configuration, or a wrong sampling moment, shows as a missing, extra or unblanked pulse in the very next machine cycle. The cycles that change inputs halfway through expose this directly. A reset qualifier state that counts wrongly moves the `int_rst` edge off the 26th or 3rd clock, and the bench samples `int_rst` at exactly those clocks.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [2:0] {
        ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6
    } mstate_e;

    typedef enum logic [1:0] {
        RQ_IDLE, RQ_COUNT, RQ_HOLD
    } rqstate_e;

    typedef struct packed {
        logic xdata;
        logic tblrd;
        logic ext_exec;
        logic ale_off;
    } cyc_cfg_t;

    localparam int unsigned STATES_PER_MC = 6;
    localparam int unsigned OSC_PER_STATE = 2;
endpackage

// File: rtl/xbs_phase_seq.sv
module xbs_phase_seq
    import xbus_pkg::*;
(
    input  logic    clk,
    input  logic    por_n,
    output mstate_e state_nx,
    output logic    wrap_nx
);
    mstate_e state_q;
    logic    half_q;
    logic    half_nx;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_S1;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            half_q  <= half_nx;
        end
    end

    // next-state logic: one state step per two oscillator periods
    always_comb begin
        half_nx  = ~half_q;
        state_nx = state_q;
        if (half_q) begin
            unique case (state_q)
                ST_S1:   state_nx = ST_S2;
                ST_S2:   state_nx = ST_S3;
                ST_S3:   state_nx = ST_S4;
                ST_S4:   state_nx = ST_S5;
                ST_S5:   state_nx = ST_S6;
                ST_S6:   state_nx = ST_S1;
                default: state_nx = ST_S1;
            endcase
        end
        wrap_nx = half_q && (state_q == ST_S6);
    end
endmodule

// File: rtl/xbs_strobe_out.sv
module xbs_strobe_out
    import xbus_pkg::*;
(
    input  logic     clk,
    input  logic     por_n,
    input  mstate_e  state_nx,
    input  logic     wrap_nx,
    input  cyc_cfg_t cfg_in,
    output logic     ale,
    output logic     psen_n
);
    cyc_cfg_t cfg_q;
    cyc_cfg_t cfg_nx;
    logic     ale_en;
    logic     ale_d;
    logic     psen_d_n;

    // configuration is latched once per machine cycle
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= '0;
        else if (wrap_nx) cfg_q <= cfg_in;
    end

    always_comb begin
        cfg_nx   = wrap_nx ? cfg_in : cfg_q;
        ale_en   = !cfg_nx.ale_off || cfg_nx.ext_exec || cfg_nx.xdata || cfg_nx.tblrd;
        ale_d    = 1'b0;
        psen_d_n = 1'b1;
        unique case (state_nx)
            ST_S1:        ale_d    = 1'b1;
            ST_S4:        ale_d    = !cfg_nx.xdata;
            ST_S3, ST_S6: psen_d_n = !(cfg_nx.ext_exec && !cfg_nx.xdata);
            default: begin
                ale_d    = 1'b0;
                psen_d_n = 1'b1;
            end
        endcase
        if (!ale_en) ale_d = 1'b1;
    end

    // output registers: values for the state being entered
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            ale    <= 1'b1;
            psen_n <= 1'b1;
        end else begin
            ale    <= ale_d;
            psen_n <= psen_d_n;
        end
    end
endmodule

// File: rtl/xbs_rst_qual.sv
module xbs_rst_qual
    import xbus_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned HOLD_CLKS   = 24
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    output logic int_rst
);
    localparam int unsigned CNT_W = $clog2(HOLD_CLKS + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   pin_s;
    rqstate_e               rq_q, rq_nx;
    logic [CNT_W-1:0]       cnt_q, cnt_nx;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rst_pin};
    end
    assign pin_s = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rq_q  <= RQ_IDLE;
            cnt_q <= '0;
        end else begin
            rq_q  <= rq_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        rq_nx  = rq_q;
        cnt_nx = cnt_q;
        unique case (rq_q)
            RQ_IDLE: begin
                cnt_nx = '0;
                if (pin_s) begin
                    rq_nx  = RQ_COUNT;
                    cnt_nx = CNT_W'(1);
                end
            end
            RQ_COUNT: begin
                if (!pin_s) begin
                    rq_nx  = RQ_IDLE;
                    cnt_nx = '0;
                end else if (cnt_q == CNT_W'(HOLD_CLKS - 1)) begin
                    rq_nx = RQ_HOLD;
                end else begin
                    cnt_nx = cnt_q + CNT_W'(1);
                end
            end
            RQ_HOLD: begin
                if (!pin_s) begin
                    rq_nx  = RQ_IDLE;
                    cnt_nx = '0;
                end
            end
            default: begin
                rq_nx  = RQ_IDLE;
                cnt_nx = '0;
            end
        endcase
    end

    // output process
    always_comb int_rst = (rq_q == RQ_HOLD);
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int unsigned RST_MC      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin,
    input  logic xdata_acc,
    input  logic tblrd_acc,
    input  logic ext_exec,
    input  logic ale_off,
    output logic ale,
    output logic psen_n,
    output logic int_rst
);
    localparam int unsigned HOLD_CLKS = RST_MC * STATES_PER_MC * OSC_PER_STATE;

    mstate_e  state_nx;
    logic     wrap_nx;
    cyc_cfg_t cfg_in;

    assign cfg_in = '{xdata: xdata_acc, tblrd: tblrd_acc, ext_exec: ext_exec, ale_off: ale_off};

    xbs_phase_seq u_seq (
        .clk      (clk),
        .por_n    (por_n),
        .state_nx (state_nx),
        .wrap_nx  (wrap_nx)
    );

    xbs_strobe_out u_out (
        .clk      (clk),
        .por_n    (por_n),
        .state_nx (state_nx),
        .wrap_nx  (wrap_nx),
        .cfg_in   (cfg_in),
        .ale      (ale),
        .psen_n   (psen_n)
    );

    xbs_rst_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .HOLD_CLKS   (HOLD_CLKS)
    ) u_rq (
        .clk     (clk),
        .por_n   (por_n),
        .rst_pin (rst_pin),
        .int_rst (int_rst)
    );
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk #(
    parameter int unsigned HOLD_CLKS = 24
) (
    input logic clk,
    input logic por_n,
    input logic rst_pin,
    input logic ale,
    input logic psen_n,
    input logic int_rst
);
    logic [15:0] hi_cnt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)              hi_cnt <= '0;
        else if (!rst_pin)       hi_cnt <= '0;
        else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 16'd1;
    end

    AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ale) |=> ale);                                          // R3
    AST_PSEN_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
        $fell(psen_n) |=> !psen_n);                                   // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!por_n)
        !psen_n |-> !ale);                                            // R8
    AST_RST_MIN_HIGH: assert property (@(posedge clk) disable iff (!por_n)
        $rose(int_rst) |-> (hi_cnt >= 16'(HOLD_CLKS)));               // R9
    AST_RST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        (!$past(rst_pin) && !$past(rst_pin, 2) && !$past(rst_pin, 3)) |-> !int_rst); // R10
endmodule

bind xbus_strobe_gen xbus_strobe_chk #(.HOLD_CLKS(HOLD_CLKS)) u_chk (
    .clk     (clk),
    .por_n   (por_n),
    .rst_pin (rst_pin),
    .ale     (ale),
    .psen_n  (psen_n),
    .int_rst (int_rst)
);

// File: tb/sim_xbus_strobe_gen.sv
module sim_xbus_strobe_gen;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 50000;

    typedef struct {
        logic  ale;
        logic  psen_n;
        string req;
        int    ph;
    } exp_t;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin = 1'b0;
    logic xdata_acc = 1'b0;
    logic tblrd_acc = 1'b0;
    logic ext_exec = 1'b0;
    logic ale_off = 1'b0;
    logic ale, psen_n, int_rst;

    int   n_cmp = 0;
    int   n_bad = 0;
    int   ph = 0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    xbus_strobe_gen u0 (
        .clk(clk), .por_n(por_n), .rst_pin(rst_pin),
        .xdata_acc(xdata_acc), .tblrd_acc(tblrd_acc),
        .ext_exec(ext_exec), .ale_off(ale_off),
        .ale(ale), .psen_n(psen_n), .int_rst(int_rst)
    );

    // independent phase count: edges since power-on release, modulo 12
    always @(posedge clk) ph <= !por_n ? 0 : (ph == 11 ? 0 : ph + 1);

    task automatic chk(string req, string what, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // driver: applies one machine cycle's inputs and pushes twelve expected items
    task automatic run_cycle(string req, logic xd, logic tb, logic ex, logic off, logic glitch);
        logic en;
        exp_t it;
        do @(negedge clk); while (ph != 11);
        xdata_acc = xd; tblrd_acc = tb; ext_exec = ex; ale_off = off;
        en = !off || ex || xd || tb;
        for (int p = 0; p < 12; p++) begin
            it.ale    = !en ? 1'b1 : ((p <= 1) || (!xd && (p == 6 || p == 7)));
            it.psen_n = !(ex && !xd && (p == 4 || p == 5 || p == 10 || p == 11));
            it.req    = req;
            it.ph     = p;
            sb_q.push_back(it);
        end
        if (glitch) begin
            do @(negedge clk); while (ph != 2);
            xdata_acc = ~xd; tblrd_acc = ~tb; ext_exec = ~ex; ale_off = ~off;
        end
    endtask

    // monitor: pops and compares one item per oscillator period
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            chk(it.req, $sformatf("ale phase %0d", it.ph), ale, it.ale);
            chk(it.req, $sformatf("psen_n phase %0d", it.ph), psen_n, it.psen_n);
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (R1..R11 run incomplete)");
        finish_run();
    end

    initial begin
        bit seen;
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "ale in reset", ale, 1'b1);
        chk("R1", "psen_n in reset", psen_n, 1'b1);
        chk("R1", "int_rst in reset", int_rst, 1'b0);
        por_n = 1'b1;

        // R9: qualification window
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (25) @(posedge clk);
        #1 chk("R9", "int_rst after 25 edges", int_rst, 1'b0);
        @(posedge clk);
        #1 chk("R9", "int_rst after 26 edges", int_rst, 1'b1);

        // R10: release latency
        @(negedge clk);
        rst_pin = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R10", "int_rst 2 edges after release", int_rst, 1'b1);
        @(posedge clk);
        #1 chk("R10", "int_rst 3 edges after release", int_rst, 1'b0);

        // R10: short pulse is rejected
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (20) @(negedge clk);
        rst_pin = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(posedge clk);
            #1 if (int_rst) seen = 1'b1;
        end
        chk("R10", "int_rst after short pulse", seen, 1'b0);

        // scoreboarded machine cycles
        run_cycle("R2",  0, 0, 0, 0, 0);
        run_cycle("R4",  0, 0, 1, 0, 0);
        run_cycle("R6",  1, 0, 0, 0, 0);
        run_cycle("R6",  1, 0, 1, 0, 0);
        run_cycle("R7",  0, 0, 0, 1, 0);
        run_cycle("R11", 0, 1, 0, 1, 0);
        run_cycle("R7",  1, 0, 0, 1, 0);
        run_cycle("R8",  0, 0, 1, 1, 0);
        run_cycle("R11", 0, 1, 1, 0, 0);
        run_cycle("R5",  0, 0, 1, 0, 1);
        run_cycle("R5",  1, 1, 0, 1, 1);
        run_cycle("R3",  0, 0, 1, 0, 0);
        run_cycle("R7",  0, 0, 0, 1, 0);
        run_cycle("R2",  0, 0, 0, 0, 0);
        while (sb_q.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule